// File: doc/BRIEF.md
# Daisy-Chained TDM Audio Shift Port

This block is the serial side of one converter device in a daisy-chained time-division-multiplexed audio link. Each device holds a shift register of eight 32-bit slots. When a frame starts, the register takes a parallel load of the converter input words. During the frame those words shift out toward the host, and bits from the next device down the chain, or from the host, shift in behind them. When the next frame starts, the bits that have been shifted in are handed to the output converters as eight parallel words.

Two identical devices can be chained. The first device's serial input takes the second device's serial output, and the host drives the second device's serial input. The result is one frame twice the register length. During that frame every input-converter bit reaches the host and every output-converter bit reaches its device. A strap input selects the role. The master divides the system clock into a bit clock and produces the frame sync. A slave follows the bit clock and frame sync it receives from the master. Both devices must run from the same system clock and reset.

Top module: `tdmChainPort`

## Requirements
- R1: In master mode, bitClkOut has a period of CLK_DIV system clocks (CLK_DIV even, at least 4): it is high for half the period and low for the other half. frameSyncOut rises together with a falling bitClkOut edge, stays high for one bit period, and recurs every FRAME_BITS bit periods (512 by default).
- R2: Slot k (0 = L1, 1 = L2, 2 = L3, 3 = L4, 4 = R1, 5 = R2, 6 = R3, 7 = R4) of adcWords sits at bits [(SLOTS-1-k)*SLOT_W +: SLOT_W]. Serial bit n of a device's frame equals adcWords[REG_W-1-n], so L1 goes first and each slot goes most significant bit first.
- R3: serOut changes only after a falling bit-clock edge. serIn is sampled after a rising bit-clock edge.
- R4: adcWords is loaded only at a frame start (a falling bit-clock edge with frame sync high). Changes to adcWords at any other time have no effect on the bits sent.
- R5: Serial output bit REG_W+n of a frame equals the serIn bit received at position n. Two chained devices therefore carry 2*REG_W bits, with the first device's slots ahead of the second device's.
- R6: At each frame start, dacWords takes the last REG_W bits received before that edge, with the earliest of them in the most significant position.
- R7: dacValid is a single-cycle pulse that occurs only at a frame start. It is suppressed at the first frame start after reset.
- R8: Reset clears serOut, dacWords, dacValid and the shift register, and holds frameSyncOut low.
- R9: With isMaster low, the device times itself from bitClkIn and frameSyncIn, and it holds bitClkOut and frameSyncOut low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rstN | input | 1 | Active-low synchronous reset |
| isMaster | input | 1 | Role strap: 1 = generate bit clock and frame sync |
| bitClkIn | input | 1 | Bit clock from the master (slave mode) |
| frameSyncIn | input | 1 | Frame sync from the master (slave mode) |
| serIn | input | 1 | Serial data from the downstream device or the host |
| adcWords | input | SLOTS*SLOT_W | Eight input-converter words, L1 in the top word |
| bitClkOut | output | 1 | Generated bit clock (master), low in slave mode |
| frameSyncOut | output | 1 | Generated frame sync (master), low in slave mode |
| serOut | output | 1 | Serial data toward the host |
| dacWords | output | SLOTS*SLOT_W | Eight output-converter words captured in the last frame |
| dacValid | output | 1 | One-cycle strobe when dacWords is renewed |

## Verification
The shift register is mostly hidden state. If it holds one wrong bit, or shifts one position too few or too many, the error shows on serOut during the current frame. It shows again at the next frame start, when the wrong bits land in dacWords. The bench runs a master and a slave chained together with a host model, compares every word the host captures, and compares both devices' dacWords once per frame. A faulty bit counter or a wrong frame-start decision shows as a frame-sync period other than FRAME_BITS, as a slot that is rotated, or as dacValid at the wrong frame. Each of these is seen within one frame.

// File: rtl/tdmChainPkg.sv
package tdmChainPkg;
  // Strobes issued by the frame timing to the shift datapath, one system clock wide
  typedef struct packed {
    logic frameStart; // falling bit-clock edge with frame sync high
    logic shiftIn;    // rising bit-clock edge: capture serIn
    logic driveOut;   // falling bit-clock edge: present next bit
    logic emitValid;  // frame start after a complete frame
  } tdmStrobes_t;
endpackage

// File: rtl/tdmFrameTiming.sv
module tdmFrameTiming
  import tdmChainPkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        isMaster,
  input  logic        bitClkIn,
  input  logic        frameSyncIn,
  output logic        genBitClk,
  output logic        genFrameSync,
  output tdmStrobes_t strobes
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_MID  = DIV_W'(HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;

  // Master clock divider and frame counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt       <= '0;
      bitCnt       <= BIT_LAST;
      genBitClk    <= 1'b0;
      genFrameSync <= 1'b0;
    end else begin
      if (divCnt == DIV_LAST) begin
        divCnt       <= '0;
        genBitClk    <= 1'b0;
        bitCnt       <= (bitCnt == BIT_LAST) ? '0 : bitCnt + 1'b1;
        genFrameSync <= (bitCnt == BIT_LAST);
      end else begin
        divCnt <= divCnt + 1'b1;
        if (divCnt == DIV_MID) genBitClk <= 1'b1;
      end
    end
  end

  // Edge detection on the selected timing source
  logic bitClkQ, bitClkPrev, frameSyncQ, primed;
  logic riseEvt, fallEvt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitClkQ    <= 1'b0;
      bitClkPrev <= 1'b0;
      frameSyncQ <= 1'b0;
    end else begin
      bitClkQ    <= isMaster ? genBitClk : bitClkIn;
      frameSyncQ <= isMaster ? genFrameSync : frameSyncIn;
      bitClkPrev <= bitClkQ;
    end
  end

  assign riseEvt = bitClkQ & ~bitClkPrev;
  assign fallEvt = ~bitClkQ & bitClkPrev;

  always_ff @(posedge clk) begin
    if (!rstN)                   primed <= 1'b0;
    else if (fallEvt && frameSyncQ) primed <= 1'b1;
  end

  always_comb begin
    strobes.frameStart = fallEvt & frameSyncQ;
    strobes.shiftIn    = riseEvt;
    strobes.driveOut   = fallEvt;
    strobes.emitValid  = fallEvt & frameSyncQ & primed;
  end
endmodule

// File: rtl/tdmShiftPath.sv
module tdmShiftPath
  import tdmChainPkg::*;
#(
  parameter int REG_W = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  tdmStrobes_t      strobes,
  input  logic             serIn,
  input  logic [REG_W-1:0] adcWords,
  output logic             serOut,
  output logic [REG_W-1:0] dacWords,
  output logic             dacValid
);
  localparam int TOP = REG_W - 1;

  logic [REG_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      serOut   <= 1'b0;
      dacWords <= '0;
      dacValid <= 1'b0;
    end else begin
      dacValid <= strobes.emitValid;
      if (strobes.frameStart) begin
        dacWords <= shiftReg;
        shiftReg <= adcWords;
        serOut   <= adcWords[TOP];
      end else begin
        if (strobes.shiftIn)  shiftReg <= {shiftReg[TOP-1:0], serIn};
        if (strobes.driveOut) serOut   <= shiftReg[TOP];
      end
    end
  end
endmodule

// File: rtl/tdmChainPort.sv
module tdmChainPort
  import tdmChainPkg::*;
#(
  parameter int SLOT_W     = 32,
  parameter int SLOTS      = 8,
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 512
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    isMaster,
  input  logic                    bitClkIn,
  input  logic                    frameSyncIn,
  input  logic                    serIn,
  input  logic [SLOTS*SLOT_W-1:0] adcWords,
  output logic                    bitClkOut,
  output logic                    frameSyncOut,
  output logic                    serOut,
  output logic [SLOTS*SLOT_W-1:0] dacWords,
  output logic                    dacValid
);
  localparam int REG_W = SLOTS * SLOT_W;

  tdmStrobes_t strobes;
  logic genBitClk, genFrameSync;

  tdmFrameTiming #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) timing (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .bitClkIn(bitClkIn), .frameSyncIn(frameSyncIn),
    .genBitClk(genBitClk), .genFrameSync(genFrameSync),
    .strobes(strobes)
  );

  tdmShiftPath #(.REG_W(REG_W)) path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .serIn(serIn),
    .adcWords(adcWords), .serOut(serOut),
    .dacWords(dacWords), .dacValid(dacValid)
  );

  assign bitClkOut    = isMaster & genBitClk;
  assign frameSyncOut = isMaster & genFrameSync;
endmodule

// File: rtl/tdmChainChecker.sv
module tdmChainChecker #(
  parameter int REG_W = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic             isMaster,
  input logic             frameSyncIn,
  input logic             bitClkOut,
  input logic             frameSyncOut,
  input logic [REG_W-1:0] dacWords,
  input logic             dacValid
);
  logic frameSel;
  assign frameSel = isMaster ? frameSyncOut : frameSyncIn;

  assert_sync_on_fall_R1: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && $rose(frameSyncOut)) |-> $fell(bitClkOut));

  assert_clk_high_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && $rose(bitClkOut)) |=> bitClkOut);

  assert_dac_at_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    $changed(dacWords) |-> frameSel);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |=> !dacValid);

  assert_valid_in_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |-> frameSel);
endmodule

bind tdmChainPort tdmChainChecker #(.REG_W(SLOTS*SLOT_W)) chk (
  .clk(clk), .rstN(rstN), .isMaster(isMaster), .frameSyncIn(frameSyncIn),
  .bitClkOut(bitClkOut), .frameSyncOut(frameSyncOut),
  .dacWords(dacWords), .dacValid(dacValid)
);

// File: tb/tb_tdmChainPort.sv
module tb_tdmChainPort;
  localparam int SLOT_W = 32, SLOTS = 8, CLK_DIV = 4, FRAME_BITS = 512;
  localparam int REG_W = SLOT_W * SLOTS;
  localparam int NUM_FRAMES = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic hostBit = 1'b0;
  logic [REG_W-1:0] adcA = '0, adcB = '0;
  logic bclkA, fsA, serA, validA, bclkB, fsB, serB, validB;
  logic [REG_W-1:0] dacA, dacB;

  tdmChainPort #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) dut (
    .clk(clk), .rstN(rstN), .isMaster(1'b1), .bitClkIn(1'b0), .frameSyncIn(1'b0),
    .serIn(serB), .adcWords(adcA), .bitClkOut(bclkA), .frameSyncOut(fsA),
    .serOut(serA), .dacWords(dacA), .dacValid(validA));

  tdmChainPort #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) dutB (
    .clk(clk), .rstN(rstN), .isMaster(1'b0), .bitClkIn(bclkA), .frameSyncIn(fsA),
    .serIn(hostBit), .adcWords(adcB), .bitClkOut(bclkB), .frameSyncOut(fsB),
    .serOut(serB), .dacWords(dacB), .dacValid(validB));

  int checks = 0, fails = 0;

  task automatic check(input logic ok, input string req, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hostWord(input int f, input int w);
    return 32'hC3A5_0F00 ^ 32'(f * 32'h0001_1000) ^ 32'(w * 32'h0101_0011);
  endfunction

  function automatic logic [31:0] adcWord(input int d, input int f, input int k);
    return {4'(d + 1), 4'(k), 8'(f), 16'(16'hBEEF ^ 16'(f * 16'h0111) ^ 16'(k * 16'h1003))};
  endfunction

  function automatic logic [REG_W-1:0] adcVec(input int d, input int f);
    logic [REG_W-1:0] v;
    for (int k = 0; k < SLOTS; k++) v[(SLOTS-1-k)*SLOT_W +: SLOT_W] = adcWord(d, f, k);
    return v;
  endfunction

  function automatic logic [REG_W-1:0] hostVec(input int half, input int f);
    logic [REG_W-1:0] v;
    for (int k = 0; k < SLOTS; k++) v[(SLOTS-1-k)*SLOT_W +: SLOT_W] = hostWord(f, half*SLOTS + k);
    return v;
  endfunction

  int frameIdx = -1, bitPos = 0, bitsSince = 0, clksSinceRise = 0;
  int pulsesA = 0, pulsesB = 0;
  logic prevBclk = 1'b0, running = 1'b0, done = 1'b0, seenRise = 1'b0;
  logic [2*REG_W-1:0] cap;

  always @(negedge clk) begin
    if (running && !done) begin
      clksSinceRise++;
      if (validA) pulsesA++;
      if (validB) pulsesB++;
      if (prevBclk && !bclkA) begin
        bitsSince++;
        if (fsA) begin
          // R1: frame period
          if (frameIdx >= 0) check(bitsSince == FRAME_BITS, "R1 frame sync period", REG_W'(bitsSince), REG_W'(FRAME_BITS));
          frameIdx++; bitPos = 0; bitsSince = 0;
        end else bitPos++;
        if (frameIdx >= 0) hostBit = hostWord(frameIdx, bitPos / 32)[31 - (bitPos % 32)];
        // R4: change converter inputs mid-frame; must not disturb this frame
        if (frameIdx >= 0 && bitPos == 100) begin
          adcA = adcVec(0, frameIdx + 1);
          adcB = adcVec(1, frameIdx + 1);
        end
      end
      if (!prevBclk && bclkA) begin
        if (seenRise && frameIdx < 2)
          check(clksSinceRise == CLK_DIV, "R1 bit clock period", REG_W'(clksSinceRise), REG_W'(CLK_DIV));
        seenRise = 1'b1; clksSinceRise = 0;
        if (frameIdx >= 0) begin
          cap[2*REG_W-1-bitPos] = serA;
          if (bitPos == 0) begin
            // R6 / R5: previous host frame split across the chain
            check(dacA === ((frameIdx == 0) ? '0 : hostVec(0, frameIdx - 1)), "R6 R5 first device dacWords",
                  dacA, (frameIdx == 0) ? '0 : hostVec(0, frameIdx - 1));
            check(dacB === ((frameIdx == 0) ? '0 : hostVec(1, frameIdx - 1)), "R6 R9 slave dacWords",
                  dacB, (frameIdx == 0) ? '0 : hostVec(1, frameIdx - 1));
            // R7: no strobe on first frame after reset
            check(validA === (frameIdx >= 1), "R7 master dacValid", REG_W'(validA), REG_W'(frameIdx >= 1));
            check(validB === (frameIdx >= 1), "R7 slave dacValid", REG_W'(validB), REG_W'(frameIdx >= 1));
            // R9: slave outputs held low
            check(!bclkB && !fsB, "R9 slave timing outputs", REG_W'({bclkB, fsB}), '0);
            if (frameIdx == NUM_FRAMES) done = 1'b1;
          end
          if (bitPos == 2*REG_W - 1) begin
            // R2 R3 R4 R5: slot-by-slot comparison of captured input words
            for (int k = 0; k < SLOTS; k++) begin
              check(cap[2*REG_W-1-k*SLOT_W -: SLOT_W] === adcWord(0, frameIdx, k), "R2 R4 first device slot",
                    REG_W'(cap[2*REG_W-1-k*SLOT_W -: SLOT_W]), REG_W'(adcWord(0, frameIdx, k)));
              check(cap[REG_W-1-k*SLOT_W -: SLOT_W] === adcWord(1, frameIdx, k), "R5 R3 chained slot",
                    REG_W'(cap[REG_W-1-k*SLOT_W -: SLOT_W]), REG_W'(adcWord(1, frameIdx, k)));
            end
          end
        end
      end
      prevBclk = bclkA;
    end
  end

  initial begin
    int cyc;
    adcA = adcVec(0, 0);
    adcB = adcVec(1, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check(serA === 1'b0 && serB === 1'b0, "R8 serOut reset", REG_W'({serA, serB}), '0);
    check(dacA === '0 && dacB === '0, "R8 dacWords reset", dacA | dacB, '0);
    check(!validA && !validB && !fsA, "R8 strobes reset", REG_W'({validA, validB, fsA}), '0);
    rstN = 1'b1;
    running = 1'b1;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog", REG_W'(cyc), '0);
    // R7: one strobe per frame start except the first
    check(pulsesA == NUM_FRAMES, "R7 master pulse count", REG_W'(pulsesA), REG_W'(NUM_FRAMES));
    check(pulsesB == NUM_FRAMES, "R7 slave pulse count", REG_W'(pulsesB), REG_W'(NUM_FRAMES));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule